// File: doc/BRIEF.md
# Smart Card Character Transmitter with Start-Bit Spacing

This block drives the serial I/O line toward a smart card. Software places one byte at a time into a single-entry holding buffer. As soon as the serial shifter is free, the byte is framed and moved across. Framing is a low start bit, eight data bits and one parity bit. The byte is translated into the selected coding convention on the way. The buffer-empty flag tells the writer when the next byte can be accepted.

The shifter is "free" only once a programmable minimum time has passed since the previous start bit. This spacing is counted in ticks of a sub-bit timing strobe, with ten ticks per elementary time unit (ETU). A guard register adds whole ETUs to a 12 ETU base. Its all-ones value instead selects a shorter, protocol-dependent fractional spacing.

A hold input lets an outside retransmission engine borrow the shifter. While hold is high, the block loads nothing new. Time spent under hold is not counted toward the spacing.

Top module: `sc_tx_guard`

## Requirements
- R1: After reset the line is high, the buffer-empty flag is 0 and no character is queued.
- R2: While tx_en is low, the flag reads 0, the line is high, any queued byte is dropped and a frame in progress is abandoned. One cycle after tx_en rises, the flag reads 1.
- R3: A write strobe accepted into an empty buffer drives the flag to 0 on the next cycle. If the shifter is free, the byte moves into it one cycle later and the flag returns to 1.
- R4: In direct convention (conv_direct=1), the frame is: start bit low, then data bits least significant first with 1 sent high, then even parity over the data. Each bit lasts 10 ticks, and the line is high after the parity bit.
- R5: In inverse convention (conv_direct=0), data bits go most significant first with every level inverted. The parity bit is the inverted even parity of the original data.
- R6: With the guard value 00h and bytes queued back to back, consecutive start bits fall exactly 120 ticks apart.
- R7: A guard value n other than FFh gives a spacing of (12+n)*10 ticks.
- R8: A guard value of FFh gives 118 ticks when proto_t1=0 and 108 ticks when proto_t1=1.
- R9: While hold is high, no byte leaves the buffer and ticks are not counted toward the spacing, so the next start bit is delayed by the number of ticks held.
- R10: A write strobe while the buffer is full is ignored. The queued byte is kept and no extra frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_en | input | 1 | Transmit mode enable |
| wr_stb | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to send |
| conv_direct | input | 1 | 1 = direct convention, 0 = inverse |
| proto_t1 | input | 1 | 0 = T=0 protocol, 1 = T=1 protocol |
| guard_val | input | 8 | Extra guard ETUs; FFh selects fractional spacing |
| sub_tick | input | 1 | One-cycle strobe, ten per ETU |
| hold | input | 1 | Retransmission in progress; freezes the shifter |
| line_out | output | 1 | Serial line drive |
| buf_empty | output | 1 | Holding buffer can accept a byte |

## Verification
The embedded properties presume the following about the inputs:
- sub_tick is a single-cycle strobe.
- guard_val, proto_t1 and conv_direct do not change while a character is pending or on the wire.
- hold is raised only in the idle gap after a parity bit.

The stimulus follows these rules. It reconfigures only after the preceding frames have been captured and the line is idle. It raises hold solely between the end of a frame and the next start bit. It spaces its ticks evenly at one per four clocks, so that every tick counted during a hold window is known exactly.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;
  localparam int unsigned DATA_W        = 8;
  localparam int unsigned GUARD_W       = 8;
  localparam int unsigned TICKS_PER_ETU = 10;
  localparam int unsigned BASE_ETU      = 12;
  localparam int unsigned FRAME_BITS    = DATA_W + 2;
  localparam int unsigned MAX_TICKS     = (BASE_ETU + (1 << GUARD_W)) * TICKS_PER_ETU;
  localparam int unsigned CNT_W         = $clog2(MAX_TICKS + 1);
  localparam int unsigned FRAC_TICKS    = (8 * TICKS_PER_ETU) / 10;

  // Minimum distance between start bits, in sub-ETU ticks.
  function automatic logic [CNT_W-1:0] spacing_ticks(input logic [GUARD_W-1:0] g,
                                                     input logic t1);
    logic [CNT_W-1:0] r;
    if (g == {GUARD_W{1'b1}}) begin
      if (t1) r = CNT_W'((BASE_ETU - 2) * TICKS_PER_ETU + FRAC_TICKS);
      else    r = CNT_W'((BASE_ETU - 1) * TICKS_PER_ETU + FRAC_TICKS);
    end else begin
      r = CNT_W'(BASE_ETU * TICKS_PER_ETU) + CNT_W'(g) * CNT_W'(TICKS_PER_ETU);
    end
    return r;
  endfunction
endpackage

// File: rtl/sc_tx_frame_fmt.sv
module sc_tx_frame_fmt
  import sc_tx_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic [DW-1:0] data_in,
  input  logic          conv_direct,
  output logic [DW+1:0] frame_out
);
  logic          par;
  logic [DW-1:0] wire_bits;

  assign par = ^data_in;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign wire_bits[i] = conv_direct ? data_in[i] : ~data_in[DW-1-i];
  end

  // Bit 0 goes out first: start, data, parity.
  assign frame_out = {(conv_direct ? par : ~par), wire_bits, 1'b0};
endmodule

// File: rtl/sc_tx_guard_timer.sv
module sc_tx_guard_timer
  import sc_tx_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic          adv,
  input  logic [CW-1:0] limit,
  output logic          busy
);
  logic [CW-1:0] gap_q, gap_d;
  logic          busy_q, busy_d;
  logic [CW-1:0] gap_inc;

  assign gap_inc = gap_q + CW'(1);

  always_comb begin
    gap_d  = gap_q;
    busy_d = busy_q;
    if (!en) begin
      busy_d = 1'b0;
    end else if (load) begin
      gap_d  = '0;
      busy_d = 1'b1;
    end else if (adv && busy_q) begin
      gap_d = gap_inc;
      if (gap_inc >= limit) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      gap_q  <= gap_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

  assert_gap_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && busy_q && !adv && !load) |=> $stable(gap_q));

  assert_no_early_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && busy_q && !load && (gap_inc < limit)) |=> busy_q);
endmodule

// File: rtl/sc_tx_shifter.sv
module sc_tx_shifter
  import sc_tx_pkg::*;
#(
  parameter int unsigned FB  = FRAME_BITS,
  parameter int unsigned TPE = TICKS_PER_ETU
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic          adv,
  input  logic [FB-1:0] frame_in,
  output logic          line_out
);
  localparam int unsigned PW = $clog2(TPE);

  logic [FB-1:0] sh_q, sh_d;
  logic [PW-1:0] ph_q, ph_d;

  always_comb begin
    sh_d = sh_q;
    ph_d = ph_q;
    if (!en) begin
      sh_d = '1;
      ph_d = '0;
    end else if (load) begin
      sh_d = frame_in;
      ph_d = '0;
    end else if (adv) begin
      if (ph_q == PW'(TPE - 1)) begin
        ph_d = '0;
        sh_d = {1'b1, sh_q[FB-1:1]};
      end else begin
        ph_d = ph_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1;
      ph_q <= '0;
    end else begin
      sh_q <= sh_d;
      ph_q <= ph_d;
    end
  end

  assign line_out = sh_q[0];

  assert_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load) |=> !line_out);
endmodule

// File: rtl/sc_tx_guard.sv
module sc_tx_guard
  import sc_tx_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned GW = GUARD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          conv_direct,
  input  logic          proto_t1,
  input  logic [GW-1:0] guard_val,
  input  logic          sub_tick,
  input  logic          hold,
  output logic          line_out,
  output logic          buf_empty
);
  localparam int unsigned FB = DW + 2;

  logic [1:0]    rst_sync_q;
  logic          rst_i_n;
  logic          en_q;
  logic          bv_q, bv_d;
  logic [DW-1:0] bd_q, bd_d;
  logic          busy, load, adv;
  logic [FB-1:0] frame;
  logic [CNT_W-1:0] limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign load  = tx_en && bv_q && !busy && !hold;
  assign adv   = tx_en && sub_tick && busy && !hold;
  assign limit = spacing_ticks(guard_val, proto_t1);

  always_comb begin
    bv_d = bv_q;
    bd_d = bd_q;
    if (!tx_en) begin
      bv_d = 1'b0;
    end else if (load) begin
      bv_d = 1'b0;
    end else if (wr_stb && !bv_q) begin
      bv_d = 1'b1;
      bd_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      en_q <= 1'b0;
      bv_q <= 1'b0;
      bd_q <= '0;
    end else begin
      en_q <= tx_en;
      bv_q <= bv_d;
      bd_q <= bd_d;
    end
  end

  assign buf_empty = en_q && !bv_q;

  sc_tx_frame_fmt #(.DW(DW)) fmt_i (
    .data_in(bd_q), .conv_direct(conv_direct), .frame_out(frame));

  sc_tx_guard_timer #(.CW(CNT_W)) tmr_i (
    .clk(clk), .rst_n(rst_i_n), .en(tx_en), .load(load), .adv(adv),
    .limit(limit), .busy(busy));

  sc_tx_shifter #(.FB(FB), .TPE(TICKS_PER_ETU)) shf_i (
    .clk(clk), .rst_n(rst_i_n), .en(tx_en), .load(load), .adv(adv),
    .frame_in(frame), .line_out(line_out));

  assert_off_idle_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    !tx_en |=> (line_out && !buf_empty));

  assert_write_fills_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (tx_en && wr_stb && buf_empty) |=> !buf_empty);

  assert_full_write_kept_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (tx_en && bv_q && wr_stb && !load) |=> (bv_q && bd_q == $past(bd_q)));

  assert_hold_blocks_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (tx_en && hold && bv_q) |=> bv_q);
endmodule

// File: tb/sc_tx_guard_tb.sv
module sc_tx_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic       conv_direct = 1'b1;
  logic       proto_t1 = 1'b0;
  logic [7:0] guard_val = '0;
  logic       sub_tick = 1'b0;
  logic       hold = 1'b0;
  logic       line_out;
  logic       buf_empty;

  int checks = 0;
  int fails = 0;

  sc_tx_guard dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_stb(wr_stb), .wr_data(wr_data),
    .conv_direct(conv_direct), .proto_t1(proto_t1), .guard_val(guard_val),
    .sub_tick(sub_tick), .hold(hold), .line_out(line_out), .buf_empty(buf_empty));

  always #4 clk = ~clk;

  // Tick source: one strobe every four clocks, changed on falling edges.
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      sub_tick = (cyc % 4 == 0);
    end
  end

  // Line monitor: stamps start bits in ticks and samples each bit mid-period.
  int         tick_cnt = 0;
  int         nfr = 0;
  int         stamp [0:31];
  logic [10:0] cap [0:31];
  logic [10:0] cur = '0;
  logic        cap_on = 1'b0;
  logic        line_prev = 1'b1;
  int          k = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (line_prev && !line_out && !cap_on) begin
        cap_on = 1'b1;
        k = 0;
        stamp[nfr % 32] = tick_cnt;
      end
      if (sub_tick) begin
        tick_cnt++;
        if (cap_on) begin
          k++;
          if (k % 10 == 5) begin
            cur[(k - 5) / 10] = line_out;
            if (k == 105) begin
              cap[nfr % 32] = cur;
              nfr++;
              cap_on = 1'b0;
            end
          end
        end
      end
      line_prev = line_out;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] exp_frame(input logic [7:0] d, input bit direct);
    logic [10:0] f;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[i+1] = direct ? d[i] : ~d[7-i];
    f[9]  = direct ? ^d : ~(^d);
    f[10] = 1'b1;
    return f;
  endfunction

  task automatic align();
    @(posedge clk iff sub_tick);
    @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_stb  = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  task automatic wait_empty();
    for (int i = 0; i < 4000 && !buf_empty; i++) @(negedge clk);
  endtask

  task automatic wait_frames(input int n);
    for (int i = 0; i < 4000 && nfr < n; i++) @(negedge clk);
  endtask

  task automatic test_reset();
    check(line_out == 1'b1, "R1 line after reset", line_out, 1);
    check(buf_empty == 1'b0, "R1 flag after reset", buf_empty, 0);
    tx_en = 1'b1;
    @(negedge clk);
    check(buf_empty == 1'b1, "R2 flag on entering transmit", buf_empty, 1);
  endtask

  task automatic test_direct();
    int base;
    conv_direct = 1'b1; guard_val = 8'h00; proto_t1 = 1'b0;
    align();
    base = nfr;
    do_write(8'h5A);
    check(buf_empty == 1'b0, "R3 flag cleared by write", buf_empty, 0);
    @(negedge clk);
    check(buf_empty == 1'b1, "R3 flag set after move", buf_empty, 1);
    do_write(8'hC3);
    wait_frames(base + 2);
    check(cap[base % 32] == exp_frame(8'h5A, 1), "R4 direct frame 5A",
          cap[base % 32], exp_frame(8'h5A, 1));
    check(cap[(base+1) % 32] == exp_frame(8'hC3, 1), "R4 direct frame C3",
          cap[(base+1) % 32], exp_frame(8'hC3, 1));
    check(stamp[(base+1) % 32] - stamp[base % 32] == 120, "R6 spacing guard 00h",
          stamp[(base+1) % 32] - stamp[base % 32], 120);
  endtask

  task automatic test_inverse();
    int base;
    conv_direct = 1'b0;
    align();
    base = nfr;
    do_write(8'h3B);
    wait_empty();
    do_write(8'h01);
    wait_frames(base + 2);
    check(cap[base % 32] == exp_frame(8'h3B, 0), "R5 inverse frame 3B",
          cap[base % 32], exp_frame(8'h3B, 0));
    check(cap[(base+1) % 32] == exp_frame(8'h01, 0), "R5 inverse frame 01",
          cap[(base+1) % 32], exp_frame(8'h01, 0));
    conv_direct = 1'b1;
  endtask

  task automatic spacing_case(input logic [7:0] g, input logic t1, input int exp,
                              input string tag);
    int base;
    wait_frames(nfr);
    repeat (600) @(negedge clk);
    guard_val = g; proto_t1 = t1;
    align();
    base = nfr;
    do_write(8'hA5);
    wait_empty();
    do_write(8'h0F);
    wait_frames(base + 2);
    check(stamp[(base+1) % 32] - stamp[base % 32] == exp, tag,
          stamp[(base+1) % 32] - stamp[base % 32], exp);
  endtask

  task automatic test_hold();
    int base;
    repeat (600) @(negedge clk);
    guard_val = 8'h00; proto_t1 = 1'b0;
    align();
    base = nfr;
    do_write(8'h11);
    wait_empty();
    do_write(8'h22);
    wait_frames(base + 1);
    align();
    hold = 1'b1;
    repeat (40) @(negedge clk);
    hold = 1'b0;
    wait_frames(base + 2);
    check(stamp[(base+1) % 32] - stamp[base % 32] == 130, "R9 hold ticks excluded",
          stamp[(base+1) % 32] - stamp[base % 32], 130);
  endtask

  task automatic test_full();
    int base;
    repeat (600) @(negedge clk);
    align();
    base = nfr;
    do_write(8'h66);
    wait_empty();
    do_write(8'h77);
    do_write(8'h88);
    wait_frames(base + 2);
    repeat (1200) @(negedge clk);
    check(nfr == base + 2, "R10 write while full ignored", nfr - base, 2);
    check(cap[(base+1) % 32] == exp_frame(8'h77, 1), "R10 queued byte kept",
          cap[(base+1) % 32], exp_frame(8'h77, 1));
  endtask

  task automatic test_disable();
    int snap;
    repeat (600) @(negedge clk);
    align();
    do_write(8'h99);
    wait_empty();
    do_write(8'hAA);
    repeat (120) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    check(line_out == 1'b1, "R2 line released when disabled", line_out, 1);
    check(buf_empty == 1'b0, "R2 flag low when disabled", buf_empty, 0);
    repeat (600) @(negedge clk);
    snap = nfr;
    tx_en = 1'b1;
    @(negedge clk);
    check(buf_empty == 1'b1, "R2 flag after re-enable", buf_empty, 1);
    repeat (800) @(negedge clk);
    check(nfr == snap, "R2 queued byte dropped", nfr - snap, 0);
    check(line_out == 1'b1, "R2 line idle after re-enable", line_out, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_direct();
    test_inverse();
    spacing_case(8'h03, 1'b0, 150, "R7 spacing guard 03h");
    spacing_case(8'hFF, 1'b0, 118, "R8 guard FFh T=0");
    spacing_case(8'hFF, 1'b1, 108, "R8 guard FFh T=1");
    test_hold();
    test_full();
    test_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule